// File: doc/BRIEF.md
# Reloadable Down-Counting Interrupt Timer

This block is a memory-mapped countdown timer for use as a periodic or one-off event source. Software sets a start value and a control word over a simple synchronous register bus. Once the timer is enabled, the counter decrements by one on each pulse of the selected tick-enable input. Two such inputs exist, one fast and one slow, and clock generation happens outside the block. When the counter steps below zero it raises a level interrupt. In periodic mode the counter then refills from the load register. In free-running mode it wraps to all ones.

Software acknowledges the interrupt with a write of any value to the clear register. A usual re-arm sequence is: stop the timer through the control register, write a new load value, then enable the timer again. The counter width is a parameter, so one design serves both 16-bit and 32-bit instances. Accesses are word aligned. Reads are combinational from the address.

Top module: `reload_timer`

## Requirements
- R1: After a synchronous active-low reset, the load register, the counter and the control register read as zero, and `irq` is low.
- R2: A write to byte offset 0x00 stores the value (truncated to the counter width) in the load register and copies it into the counter on the same clock edge. If a tick arrives in the same cycle, the load wins and no interrupt is raised.
- R3: Offset 0x04 returns the current count, zero-extended to 32 bits. A write to 0x04 changes neither the counter nor any other register.
- R4: Offset 0x08 is the control register. Bit 7 enables counting, bit 6 selects periodic mode, and bit 3 selects the fast tick. Only these three bits are stored and read back; every other bit reads as zero. Offset 0x0C always reads as zero.
- R5: While enabled, the counter decrements by one in each cycle where the selected tick is high. The selected tick is `tick_fast` when bit 3 is 1 and `tick_slow` when bit 3 is 0. The unselected tick has no effect.
- R6: While bit 7 is 0, ticks leave the counter unchanged and raise no interrupt.
- R7: In periodic mode (bit 6 = 1), a tick at count zero reloads the counter from the load register and sets `irq` on the next edge.
- R8: In free-running mode (bit 6 = 0), a tick at count zero wraps the counter to all ones of the counter width and sets `irq`.
- R9: `irq` is a level that stays high until software writes any data value to offset 0x0C. The write clears `irq` on that edge.
- R10: If an underflow and a write to 0x0C fall in the same cycle, `irq` stays high.
- R11: A 16-bit instance keeps only the low 16 bits of a load write and reads back with bits 31:16 at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_fast | input | 1 | Fast count-enable pulse |
| tick_slow | input | 1 | Slow count-enable pulse |
| bus_addr | input | 4 | Byte offset of the access (word aligned) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Level interrupt |

## Verification
Two events can land in the same cycle. An underflow can coincide with a write to the clear register, and an underflow can coincide with a load write. The bench provokes both deliberately. It loads zero, enables the fast tick, and in the next cycle issues the clear write or a load write while `tick_fast` is high. The random phase uses small load values so these collisions also occur by chance. Each result is judged against a bench model in which an underflow sets the flag over a same-cycle clear, and a load suppresses the underflow.

// File: rtl/rtmr_pkg.sv
// Shared definitions for the reloadable down-counting timer.
// Assumes 32-bit word-aligned register accesses.
package rtmr_pkg;

    // Word index of each register (byte offset / 4).
    typedef enum logic [1:0] {
        REG_LOAD  = 2'd0,
        REG_COUNT = 2'd1,
        REG_CTRL  = 2'd2,
        REG_CLR   = 2'd3
    } reg_sel_e;

    // Stored control fields.
    typedef struct packed {
        logic run;
        logic periodic;
        logic fast;
    } ctrl_t;

    localparam int CTRL_RUN_BIT  = 7;
    localparam int CTRL_PER_BIT  = 6;
    localparam int CTRL_FAST_BIT = 3;

endpackage

// File: rtl/rtmr_regs.sv
// Register file and bus decode for the timer.
// Holds the load and control registers, creates one-cycle write strobes
// for load and clear, and forms combinational read data.
// Assumes bus_addr is a byte offset; misaligned accesses are ignored.
module rtmr_regs
    import rtmr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  cnt_q,
    output logic [CNT_W-1:0]  load_q,
    output ctrl_t             ctrl_q,
    output logic              ld_wr,
    output logic              clr_wr,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam int PAD_W = DATA_W - CNT_W;

    logic     aligned;
    reg_sel_e sel;
    logic     ctrl_wr;
    logic [DATA_W-1:0] cnt_ext;
    logic [DATA_W-1:0] load_ext;

    // Decode the word index and the write strobes.
    always_comb begin
        aligned = (bus_addr[1:0] == 2'b00);
        sel     = reg_sel_e'(bus_addr[3:2]);
        ld_wr   = bus_wr && aligned && (sel == REG_LOAD);
        ctrl_wr = bus_wr && aligned && (sel == REG_CTRL);
        clr_wr  = bus_wr && aligned && (sel == REG_CLR);
    end

    // Load register: keeps the reload value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            load_q <= '0;
        else if (ld_wr)
            load_q <= bus_wdata[CNT_W-1:0];
    end

    // Control register: keeps only the three defined bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (ctrl_wr)
            ctrl_q <= '{run:      bus_wdata[CTRL_RUN_BIT],
                        periodic: bus_wdata[CTRL_PER_BIT],
                        fast:     bus_wdata[CTRL_FAST_BIT]};
    end

    // Zero-extend counter-width values to the bus width.
    generate
        if (PAD_W > 0) begin : g_pad
            assign cnt_ext  = {{PAD_W{1'b0}}, cnt_q};
            assign load_ext = {{PAD_W{1'b0}}, load_q};
        end else begin : g_nopad
            assign cnt_ext  = cnt_q;
            assign load_ext = load_q;
        end
    endgenerate

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            unique case (sel)
                REG_LOAD:  bus_rdata = load_ext;
                REG_COUNT: bus_rdata = cnt_ext;
                REG_CTRL: begin
                    bus_rdata[CTRL_RUN_BIT]  = ctrl_q.run;
                    bus_rdata[CTRL_PER_BIT]  = ctrl_q.periodic;
                    bus_rdata[CTRL_FAST_BIT] = ctrl_q.fast;
                end
                REG_CLR:   bus_rdata = '0;
                default:   bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/rtmr_tick.sv
// Count-enable selection.
// Produces a one-cycle step request from the fast or slow tick input,
// gated by the run bit. Assumes both ticks are already synchronous to clk.
module rtmr_tick (
    input  logic run,
    input  logic fast_sel,
    input  logic tick_fast,
    input  logic tick_slow,
    output logic step
);

    // Pick the tick source and gate it with run.
    always_comb begin
        step = run && (fast_sel ? tick_fast : tick_slow);
    end

endmodule

// File: rtl/rtmr_count.sv
// Down-counter with reload and wrap.
// A load write has priority over a step. A step at zero either reloads
// (periodic) or wraps to all ones (free-running), and flags an underflow.
module rtmr_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_wr,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             step,
    input  logic             periodic,
    input  logic [CNT_W-1:0] load_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             uf_evt
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic             at_zero;
    logic [CNT_W-1:0] cnt_d;

    // Next-count selection and underflow detection.
    always_comb begin
        at_zero = (cnt_q == '0);
        uf_evt  = step && at_zero && !ld_wr;
        if (ld_wr)
            cnt_d = ld_val;
        else if (step)
            cnt_d = at_zero ? (periodic ? load_q : '1) : (cnt_q - CNT_ONE);
        else
            cnt_d = cnt_q;
    end

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

endmodule

// File: rtl/rtmr_irq.sv
// Interrupt flag. Set by an underflow, cleared by a clear write;
// a set in the same cycle wins over the clear.
module rtmr_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic uf_evt,
    input  logic clr_wr,
    output logic irq
);

    // Level flag with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else if (uf_evt)
            irq <= 1'b1;
        else if (clr_wr)
            irq <= 1'b0;
    end

endmodule

// File: rtl/reload_timer.sv
// Top level of the reloadable down-counting interrupt timer.
// Wires the register file, tick selection, counter and interrupt flag.
// Assumes CNT_W <= 32 and word-aligned accesses on a 16-byte window.
module reload_timer
    import rtmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_fast,
    input  logic        tick_slow,
    input  logic [3:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);

    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;

    logic [CNT_W-1:0] load_q;
    logic [CNT_W-1:0] cnt_q;
    ctrl_t            ctrl_q;
    logic             ld_wr;
    logic             clr_wr;
    logic             step;
    logic             uf_evt;
    logic             run_en;
    logic [CNT_W-1:0] ld_val;

    assign run_en = ctrl_q.run;
    assign ld_val = bus_wdata[CNT_W-1:0];

    rtmr_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .cnt_q     (cnt_q),
        .load_q    (load_q),
        .ctrl_q    (ctrl_q),
        .ld_wr     (ld_wr),
        .clr_wr    (clr_wr),
        .bus_rdata (bus_rdata)
    );

    rtmr_tick u_tick (
        .run       (ctrl_q.run),
        .fast_sel  (ctrl_q.fast),
        .tick_fast (tick_fast),
        .tick_slow (tick_slow),
        .step      (step)
    );

    rtmr_count #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_wr    (ld_wr),
        .ld_val   (ld_val),
        .step     (step),
        .periodic (ctrl_q.periodic),
        .load_q   (load_q),
        .cnt_q    (cnt_q),
        .uf_evt   (uf_evt)
    );

    rtmr_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .uf_evt (uf_evt),
        .clr_wr (clr_wr),
        .irq    (irq)
    );

endmodule

// File: rtl/rtmr_chk.sv
// Property checker for reload_timer, attached by bind.
module rtmr_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ld_wr,
    input logic             clr_wr,
    input logic [CNT_W-1:0] ld_val,
    input logic             uf_evt,
    input logic             run_en,
    input logic [CNT_W-1:0] cnt_q,
    input logic             irq
);

    // R1
    reset_irq_low_chk: assert property (@(posedge clk) !rst_n |=> !irq);

    // R2
    load_copies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_wr |=> (cnt_q == $past(ld_val)));

    // R6
    halt_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !ld_wr) |=> $stable(cnt_q));

    // R6
    halt_no_uf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |-> !uf_evt);

    // R7
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(uf_evt));

    // R9
    clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !uf_evt) |=> !irq);

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uf_evt |=> irq);

endmodule

bind reload_timer rtmr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_wr  (ld_wr),
    .clr_wr (clr_wr),
    .ld_val (ld_val),
    .uf_evt (uf_evt),
    .run_en (run_en),
    .cnt_q  (cnt_q),
    .irq    (irq)
);

// File: tb/reload_timer_test.sv
`timescale 1ns/1ps
module reload_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_fast = 1'b0;
    logic        tick_slow = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rd32, rd16;
    logic        irq32, irq16;

    int n_chk = 0;
    int n_bad = 0;
    int cyc_cnt = 0;
    bit done = 0;

    // Model state: index 0 = 32-bit instance, 1 = 16-bit instance.
    logic [31:0] m_load [2];
    logic [31:0] m_cnt  [2];
    logic [31:0] m_ctrl [2];
    logic        m_irq  [2];
    logic [31:0] n_load [2];
    logic [31:0] n_cnt  [2];
    logic [31:0] n_ctrl [2];
    logic        n_irq  [2];

    always #2.5 clk = ~clk;

    reload_timer #(.CNT_W(32)) uut (
        .clk(clk), .rst_n(rst_n), .tick_fast(tick_fast), .tick_slow(tick_slow),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(rd32), .irq(irq32)
    );

    reload_timer #(.CNT_W(16)) uut_w16 (
        .clk(clk), .rst_n(rst_n), .tick_fast(tick_fast), .tick_slow(tick_slow),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(rd16), .irq(irq16)
    );

    function automatic logic [31:0] wmask(input int k);
        return (k == 0) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    endfunction

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc_cnt <= cyc_cnt + 1;
        if (cyc_cnt > 150000 && !done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not end, got=%0d cycles exp<150000", cyc_cnt);
            finish_run();
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Model: reset of all registers.
    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            m_load[k] = '0; m_cnt[k] = '0; m_ctrl[k] = '0; m_irq[k] = 1'b0;
        end
    endtask

    // Model: next state from current state and this cycle's inputs.
    task automatic model_step(input int k, input logic [3:0] a, input logic w,
                              input logic [31:0] d, input logic tf, input logic ts);
        logic [31:0] mk;
        logic tick, ldw, clrw, ctw, uf;
        mk   = wmask(k);
        ldw  = w && a == 4'h0;
        ctw  = w && a == 4'h8;
        clrw = w && a == 4'hC;
        tick = m_ctrl[k][7] && (m_ctrl[k][3] ? tf : ts);
        uf   = tick && m_cnt[k] == 0 && !ldw;
        n_load[k] = ldw ? (d & mk) : m_load[k];
        n_ctrl[k] = ctw ? (d & 32'h0000_00C8) : m_ctrl[k];
        if (ldw)       n_cnt[k] = d & mk;
        else if (tick) n_cnt[k] = (m_cnt[k] == 0) ? (m_ctrl[k][6] ? m_load[k] : mk)
                                                  : m_cnt[k] - 1;
        else           n_cnt[k] = m_cnt[k];
        n_irq[k] = uf ? 1'b1 : (clrw ? 1'b0 : m_irq[k]);
    endtask

    function automatic logic [31:0] rd_exp(input int k, input logic [3:0] a);
        case (a)
            4'h0: return m_load[k];
            4'h4: return m_cnt[k];
            4'h8: return m_ctrl[k];
            default: return 32'h0;
        endcase
    endfunction

    // Compare every register and the interrupt of both instances.
    task automatic compare(input string tag);
        for (int i = 0; i < 4; i++) begin
            bus_addr = 4'(i * 4);
            #0.2;
            check({tag, " rd32"}, rd32, rd_exp(0, bus_addr));
            check({tag, " rd16"}, rd16, rd_exp(1, bus_addr));
        end
        check({tag, " irq32"}, {31'b0, irq32}, {31'b0, m_irq[0]});
        check({tag, " irq16"}, {31'b0, irq16}, {31'b0, m_irq[1]});
    endtask

    task automatic cyc(input string tag, input logic [3:0] a, input logic w,
                       input logic [31:0] d, input logic tf, input logic ts);
        @(negedge clk);
        bus_addr = a; bus_wr = w; bus_wdata = d; tick_fast = tf; tick_slow = ts;
        for (int k = 0; k < 2; k++) model_step(k, a, w, d, tf, ts);
        @(posedge clk);
        #1;
        for (int k = 0; k < 2; k++) begin
            m_load[k] = n_load[k]; m_cnt[k] = n_cnt[k];
            m_ctrl[k] = n_ctrl[k]; m_irq[k] = n_irq[k];
        end
        bus_wr = 1'b0; tick_fast = 1'b0; tick_slow = 1'b0;
        compare(tag);
    endtask

    task automatic peek(input logic [3:0] a);
        bus_addr = a;
        #0.2;
    endtask

    initial begin
        void'($urandom(32'd4711));
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        compare("R1 reset");

        // R2: load write copies into counter
        cyc("R2 load", 4'h0, 1, 32'd5, 0, 0);
        // R4: only bits 7,6,3 stored
        cyc("R4 ctrl", 4'h8, 1, 32'hFFFF_FFFF, 0, 0);
        peek(4'h8);
        check("R4 ctrl readback", rd32, 32'h0000_00C8);
        // R3: write to count register ignored
        cyc("R3 ro", 4'h4, 1, 32'h77, 0, 0);
        peek(4'h4);
        check("R3 count unchanged", rd32, 32'd5);
        // R5: fast selected, slow ignored
        repeat (3) cyc("R5 slow ignored", 4'h4, 0, 0, 0, 1);
        repeat (2) cyc("R5 fast steps", 4'h4, 0, 0, 1, 0);
        peek(4'h4);
        check("R5 count after 2 fast", rd32, 32'd3);
        // R7: run to underflow in periodic mode
        repeat (4) cyc("R7 periodic", 4'h4, 0, 0, 1, 0);
        peek(4'h4);
        check("R7 reload", rd32, 32'd5);
        check("R7 irq", {31'b0, irq32}, 32'd1);
        // R9: clear with idle tick
        repeat (2) cyc("R9 level held", 4'h4, 0, 0, 0, 0);
        cyc("R9 clear", 4'hC, 1, 32'hDEAD_BEEF, 0, 0);
        check("R9 irq dropped", {31'b0, irq32}, 32'd0);
        // R10: underflow and clear together
        cyc("R10 prep", 4'h0, 1, 32'd0, 0, 0);
        cyc("R10 collide", 4'hC, 1, 32'd0, 1, 0);
        check("R10 irq kept", {31'b0, irq32}, 32'd1);
        cyc("R10 clear", 4'hC, 1, 32'd1, 0, 0);
        // R2: load beats tick at zero
        cyc("R2 prep", 4'h0, 1, 32'd0, 0, 0);
        cyc("R2 priority", 4'h0, 1, 32'd9, 1, 0);
        check("R2 no irq", {31'b0, irq32}, 32'd0);
        // R8 / R11: free-running wrap, slow tick source
        cyc("R8 ctrl", 4'h8, 1, 32'h0000_0080, 0, 0);
        cyc("R11 trunc", 4'h0, 1, 32'h0001_2345, 0, 0);
        peek(4'h4);
        check("R11 16-bit count", rd16, 32'h0000_2345);
        cyc("R8 load1", 4'h0, 1, 32'd1, 0, 0);
        repeat (2) cyc("R8 wrap", 4'h4, 0, 0, 0, 1);
        peek(4'h4);
        check("R8 wrap32", rd32, 32'hFFFF_FFFF);
        check("R8 wrap16", rd16, 32'h0000_FFFF);
        cyc("R9 clear2", 4'hC, 1, 32'd0, 0, 0);
        // R6: disabled, ticks have no effect
        cyc("R6 stop", 4'h8, 1, 32'h0000_0048, 0, 0);
        cyc("R6 load0", 4'h0, 1, 32'd0, 0, 0);
        repeat (4) cyc("R6 hold", 4'h4, 0, 0, 1, 1);
        peek(4'h4);
        check("R6 count held", rd32, 32'd0);
        check("R6 no irq", {31'b0, irq32}, 32'd0);

        // Random phase: R5 R7 R8 R9 R10 mixed
        for (int i = 0; i < 3000; i++) begin
            int op;
            logic [31:0] d;
            op = int'($urandom_range(0, 99));
            d  = $urandom;
            if (op < 6)       cyc("R2 rnd load", 4'h0, 1, d % 12, $urandom_range(0,1), $urandom_range(0,1));
            else if (op < 10) cyc("R4 rnd ctrl", 4'h8, 1, d | 32'h80, $urandom_range(0,1), $urandom_range(0,1));
            else if (op < 16) cyc("R9 rnd clear", 4'hC, 1, d, $urandom_range(0,1), $urandom_range(0,1));
            else if (op < 18) cyc("R3 rnd ro", 4'h4, 1, d, $urandom_range(0,1), $urandom_range(0,1));
            else              cyc("R5 rnd tick", 4'h4, 0, 0, $urandom_range(0,1), $urandom_range(0,1));
        end

        done = 1;
        finish_run();
    end

endmodule